// File: doc/BRIEF.md
# Register-File Execute Datapath

This block is the execute stage of a small 8-bit teaching processor. It holds sixteen 8-bit working registers and an arithmetic/logic unit. The 4-bit machine opcode selects the operation directly. Each instruction also carries three 4-bit operand fields, called A, B and C here. Depending on the opcode, these fields name registers, make up an 8-bit literal, or give a rotate count. The unit writes one result back into the register file. It also produces an equality flag that a sequencer can use to decide whether to take a branch.

The sequencer presents one instruction per cycle with `exec_en` high. The register write and both outputs take effect on the next rising clock edge. Register operands are read combinationally during the issue cycle, so an instruction always sees the register values from before its own write. Memory access, floating-point arithmetic and instruction sequencing are outside this block.

Top module: `nib_exec_unit`

## Requirements
- R1: An active-high synchronous reset clears all sixteen registers to 8'h00, `wb_data` to 8'h00 and `eq_flag` to 0.
- R2: Opcode 4'h2 loads the literal {B,C} (B is the high nibble) into register A. `wb_data` shows the same byte after the edge.
- R3: Opcode 4'h5 writes (reg[B] + reg[C]) mod 256 into register A and onto `wb_data`. The carry out is discarded.
- R4: Opcodes 4'h7, 4'h8 and 4'h9 write reg[B] OR reg[C], reg[B] AND reg[C] and reg[B] XOR reg[C], in that order, into register A and onto `wb_data`.
- R5: Opcode 4'hA rotates register A right by C mod 8 positions and writes the result back into register A and onto `wb_data`. For example, 8'h9D rotated by 1 gives 8'hCE, and counts 0 and 8 leave the value unchanged.
- R6: Opcode 4'h4 copies reg[B] into reg[C] and onto `wb_data`. Field A has no effect.
- R7: On an issued instruction whose opcode is not 4, 5, 7, 8 or 9, `eq_flag` becomes 1 if reg[A] equals reg[0] before that instruction's write, and 0 otherwise. On opcodes 4, 5, 7, 8 and 9, `eq_flag` keeps its value.
- R8: Opcodes 0, 1, 3, 6, B, C, D, E and F change no register and leave `wb_data` unchanged.
- R9: While `exec_en` is low, no register, `wb_data` or `eq_flag` changes, whatever the other inputs are.
- R10: A register written by one instruction reads the new value in the next instruction. An instruction whose destination is also one of its sources uses the old value.
- R11: Register 0 is an ordinary register: it can be written, and it keeps the value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Issue strobe: the instruction on the inputs executes this cycle |
| opcode | input | 4 | Machine opcode nibble |
| fld_a | input | 4 | Operand field A: destination / rotated / compared register |
| fld_b | input | 4 | Operand field B: first source register or literal high nibble |
| fld_c | input | 4 | Operand field C: second source, move destination, literal low nibble or rotate count |
| wb_data | output | 8 | Registered value written back by the last writing instruction |
| eq_flag | output | 1 | Registered result of the comparison of reg[A] with reg[0] |

## Verification
The adder and the three logic operations are driven with every value of the first operand, each paired with sixteen spread second operands. This separates a carry-chain fault from a gate-selection fault and shows whether the S and T ports are swapped. The rotator sees every byte value with all sixteen count nibbles, applied one after another. That pattern shows whether each shift stage works and whether counts of 8 and above wrap to 0 through 7. Register-to-register moves cover every source and destination pair. The equality compare is tried with values that match and with values that differ in one bit, against every register. Unused opcodes, idle cycles and same-register source and destination are each followed by a read-back of all registers through moves.

// File: rtl/nib_exec_pkg.sv
`timescale 1ns/1ps
package nib_exec_pkg;
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OPC_LIT = 4'h2;
  localparam logic [OPW-1:0] OPC_CPY = 4'h4;
  localparam logic [OPW-1:0] OPC_SUM = 4'h5;
  localparam logic [OPW-1:0] OPC_IOR = 4'h7;
  localparam logic [OPW-1:0] OPC_CON = 4'h8;
  localparam logic [OPW-1:0] OPC_DIF = 4'h9;
  localparam logic [OPW-1:0] OPC_ROT = 4'hA;

  // opcode produces a register write
  function automatic logic op_writes(input logic [OPW-1:0] op);
    case (op)
      OPC_LIT, OPC_CPY, OPC_SUM, OPC_IOR, OPC_CON, OPC_DIF, OPC_ROT: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // opcode reads two source registers from fields B and C
  function automatic logic op_dual_src(input logic [OPW-1:0] op);
    case (op)
      OPC_SUM, OPC_IOR, OPC_CON, OPC_DIF: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // opcode occupies the read ports, so the compare result is not refreshed
  function automatic logic op_holds_eq(input logic [OPW-1:0] op);
    return op_dual_src(op) || (op == OPC_CPY);
  endfunction
endpackage

// File: rtl/nib_rf_bank.sv
`timescale 1ns/1ps
module nib_rf_bank #(
  parameter int DW   = 8,
  parameter int NREG = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr_p,
  input  logic [AW-1:0] rd_addr_q,
  output logic [DW-1:0] rd_data_p,
  output logic [DW-1:0] rd_data_q,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] cells [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) cells[i] <= '0;
    end else if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end
  end

  // combinational reads: a same-cycle write is not yet visible
  assign rd_data_p = cells[rd_addr_p];
  assign rd_data_q = cells[rd_addr_q];

  // R10: a write is held in its cell after the edge
  assert_write_visible_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cells[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/nib_rotr.sv
`timescale 1ns/1ps
module nib_rotr #(
  parameter int DW = 8,
  localparam int SW = $clog2(DW)
) (
  input  logic [DW-1:0] din,
  input  logic [SW-1:0] amount,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] stage [SW+1];
  assign stage[0] = din;

  for (genvar i = 0; i < SW; i++) begin : g_stage
    localparam int K = 1 << i;
    logic [DW-1:0] turned;
    assign turned = {stage[i][K-1:0], stage[i][DW-1:K]};
    assign stage[i+1] = amount[i] ? turned : stage[i];
  end

  assign dout = stage[SW];
endmodule

// File: rtl/nib_alu.sv
`timescale 1ns/1ps
module nib_alu
  import nib_exec_pkg::*;
#(
  parameter int DW = 8,
  parameter int FW = 4,
  localparam int SW = $clog2(DW)
) (
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  opnd_s,
  input  logic [DW-1:0]  opnd_t,
  input  logic [FW-1:0]  lit_hi,
  input  logic [FW-1:0]  lit_lo,
  output logic [DW-1:0]  result,
  output logic           does_write
);
  logic [DW-1:0]   rot_out;
  logic [2*FW-1:0] literal;

  assign literal = {lit_hi, lit_lo};

  // count taken modulo the data width by dropping upper bits
  nib_rotr #(.DW(DW)) u_rotr (
    .din    (opnd_s),
    .amount (lit_lo[SW-1:0]),
    .dout   (rot_out)
  );

  always_comb begin
    result = '0;
    case (op)
      OPC_LIT: result = DW'(literal);
      OPC_CPY: result = opnd_s;
      OPC_SUM: result = opnd_s + opnd_t;
      OPC_IOR: result = opnd_s | opnd_t;
      OPC_CON: result = opnd_s & opnd_t;
      OPC_DIF: result = opnd_s ^ opnd_t;
      OPC_ROT: result = rot_out;
      default: result = '0;
    endcase
  end

  assign does_write = op_writes(op);
endmodule

// File: rtl/nib_exec_unit.sv
`timescale 1ns/1ps
module nib_exec_unit
  import nib_exec_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 16,
  localparam int FW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           exec_en,
  input  logic [OPW-1:0] opcode,
  input  logic [FW-1:0]  fld_a,
  input  logic [FW-1:0]  fld_b,
  input  logic [FW-1:0]  fld_c,
  output logic [DW-1:0]  wb_data,
  output logic           eq_flag
);
  logic [FW-1:0] addr_p, addr_q, addr_w;
  logic [DW-1:0] val_p, val_q, alu_res;
  logic          alu_wr, rf_we, eq_now;

  // port P: field B for move and two-source ops, otherwise field A
  assign addr_p = (op_dual_src(opcode) || opcode == OPC_CPY) ? fld_b : fld_a;
  // port Q: field C for two-source ops, otherwise register 0 for the compare
  assign addr_q = op_dual_src(opcode) ? fld_c : '0;
  assign addr_w = (opcode == OPC_CPY) ? fld_c : fld_a;

  nib_rf_bank #(.DW(DW), .NREG(NREG)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .rd_addr_p (addr_p),
    .rd_addr_q (addr_q),
    .rd_data_p (val_p),
    .rd_data_q (val_q),
    .wr_en     (rf_we),
    .wr_addr   (addr_w),
    .wr_data   (alu_res)
  );

  nib_alu #(.DW(DW), .FW(FW)) u_alu (
    .op         (opcode),
    .opnd_s     (val_p),
    .opnd_t     (val_q),
    .lit_hi     (fld_b),
    .lit_lo     (fld_c),
    .result     (alu_res),
    .does_write (alu_wr)
  );

  assign rf_we  = exec_en && alu_wr;
  assign eq_now = (val_p == val_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_data <= '0;
      eq_flag <= 1'b0;
    end else if (exec_en) begin
      if (alu_wr) wb_data <= alu_res;
      if (!op_holds_eq(opcode)) eq_flag <= eq_now;
    end
  end

  // R1: reset leaves both outputs cleared
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (wb_data == '0 && !eq_flag));

  // R9: idle cycles leave the outputs alone
  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> ($stable(wb_data) && $stable(eq_flag)));

  // R8: non-writing opcodes keep the write-back output
  assert_nowrite_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (exec_en && !op_writes(opcode)) |=> $stable(wb_data));

  // R7: ops that occupy both read ports keep the compare flag
  assert_eq_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_holds_eq(opcode)) |=> $stable(eq_flag));

  // R6: a move lands its source value on the output
  assert_move_value_R6: assert property (@(posedge clk) disable iff (rst)
    (exec_en && opcode == OPC_CPY) |=> (wb_data == $past(val_p)));
endmodule

// File: tb/nib_exec_unit_test.sv
`timescale 1ns/1ps
module nib_exec_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       exec_en = 1'b0;
  logic [3:0] opcode = '0, fld_a = '0, fld_b = '0, fld_c = '0;
  logic [7:0] wb_data;
  logic       eq_flag;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] mrf [16];
  logic [7:0] mres;
  logic       meq;

  always #5 clk = ~clk;

  nib_exec_unit uut (
    .clk(clk), .rst(rst), .exec_en(exec_en), .opcode(opcode),
    .fld_a(fld_a), .fld_b(fld_b), .fld_c(fld_c),
    .wb_data(wb_data), .eq_flag(eq_flag)
  );

  function automatic logic [7:0] spin_right(input logic [7:0] x, input int k);
    logic [15:0] dbl;
    dbl = {x, x} >> (k % 8);
    return dbl[7:0];
  endfunction

  task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic check1(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  // update the model from the requirements, using pre-write values
  task automatic model_step(input logic [3:0] op, input logic [3:0] a, b, c);
    logic [7:0] v;
    logic       w;
    logic [3:0] dst;
    w = 1'b1; dst = a; v = 8'h00;
    case (op)
      4'h2: v = {b, c};
      4'h4: begin v = mrf[b]; dst = c; end
      4'h5: v = mrf[b] + mrf[c];
      4'h7: v = mrf[b] | mrf[c];
      4'h8: v = mrf[b] & mrf[c];
      4'h9: v = mrf[b] ^ mrf[c];
      4'hA: v = spin_right(mrf[a], int'(c));
      default: w = 1'b0;
    endcase
    if (!(op == 4'h4 || op == 4'h5 || op == 4'h7 || op == 4'h8 || op == 4'h9))
      meq = (mrf[a] == mrf[0]);
    if (w) begin
      mrf[dst] = v;
      mres = v;
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [3:0] a, b, c, input string tag);
    @(negedge clk);
    opcode = op; fld_a = a; fld_b = b; fld_c = c; exec_en = 1'b1;
    @(negedge clk);
    exec_en = 1'b0;
    model_step(op, a, b, c);
    check8({tag, " wb_data"}, wb_data, mres);
    check1({tag, " eq_flag"}, eq_flag, meq);
  endtask

  task automatic load(input logic [3:0] r, input logic [7:0] v, input string tag);
    run(4'h2, r, v[7:4], v[3:0], tag);
  endtask

  task automatic dump_regs(input string tag);
    for (int k = 0; k < 16; k++) begin
      run(4'h4, 4'h0, 4'(k), 4'(k), tag);
    end
  endtask

  initial begin
    for (int k = 0; k < 16; k++) mrf[k] = 8'h00;
    mres = 8'h00;
    meq  = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state of outputs and registers
    check8("R1 wb_data after reset", wb_data, 8'h00);
    check1("R1 eq_flag after reset", eq_flag, 1'b0);
    dump_regs("R1 register cleared");

    // R2: literal loads into every register
    for (int v = 0; v < 256; v++) load(4'(v % 16), 8'(v), "R2 literal load");
    dump_regs("R2 read back");

    // R11: register 0 writable and holds
    load(4'h0, 8'hA5, "R11 write reg0");
    run(4'h4, 4'h0, 4'h0, 4'h3, "R11 copy reg0");
    check8("R11 reg0 value", wb_data, 8'hA5);

    // R3 and R4: first operand swept, second operand spread
    for (int x = 0; x < 256; x++) begin
      for (int j = 0; j < 16; j++) begin
        load(4'h1, 8'(x), "R3 setup S");
        load(4'h2, 8'((j * 37 + 11 + x * 3) % 256), "R3 setup T");
        run(4'h5, 4'h3, 4'h1, 4'h2, "R3 add");
        run(4'h7, 4'h4, 4'h1, 4'h2, "R4 or");
        run(4'h8, 4'h5, 4'h2, 4'h1, "R4 and");
        run(4'h9, 4'h6, 4'h1, 4'h2, "R4 xor");
      end
    end
    load(4'h1, 8'hF0, "R3 carry setup");
    load(4'h2, 8'h25, "R3 carry setup");
    run(4'h5, 4'h3, 4'h1, 4'h2, "R3 carry");
    check8("R3 carry discarded", wb_data, 8'h15);

    // R5: rotate, including the document example and wrap of counts
    load(4'h7, 8'h9D, "R5 setup");
    run(4'hA, 4'h7, 4'h0, 4'h1, "R5 rotate by 1");
    check8("R5 9D by 1", wb_data, 8'hCE);
    run(4'hA, 4'h7, 4'h0, 4'h8, "R5 rotate by 8");
    check8("R5 count 8 unchanged", wb_data, 8'hCE);
    for (int x = 0; x < 256; x++) begin
      load(4'h7, 8'(x), "R5 setup");
      for (int c = 0; c < 16; c++) run(4'hA, 4'h7, 4'(c), 4'(c), "R5 rotate sweep");
    end

    // R6: moves over all source/destination pairs, field A irrelevant
    for (int k = 0; k < 16; k++) load(4'(k), 8'(k * 13 + 7), "R6 setup");
    for (int s = 0; s < 16; s++) begin
      for (int d = 0; d < 16; d++) run(4'h4, 4'(d ^ 5), 4'(s), 4'(d), "R6 move");
    end
    dump_regs("R6 read back");

    // R7: compare against register 0, hold on two-port ops
    for (int k = 1; k < 16; k++) begin
      load(4'h0, 8'(k * 9), "R7 setup r0");
      load(4'(k), 8'(k * 9), "R7 setup equal");
      run(4'hB, 4'(k), 4'h0, 4'h0, "R7 equal");
      check1("R7 equal flag", eq_flag, 1'b1);
      run(4'h5, 4'h1, 4'h2, 4'h3, "R7 hold after add");
      load(4'(k), 8'(k * 9) ^ 8'h10, "R7 setup differ");
      run(4'hB, 4'(k), 4'h0, 4'h0, "R7 differ");
      check1("R7 differ flag", eq_flag, 1'b0);
    end
    run(4'hB, 4'h0, 4'h0, 4'h0, "R7 self compare");

    // R8: opcodes without a write touch nothing
    for (int k = 0; k < 16; k++) load(4'(k), 8'(255 - k * 11), "R8 setup");
    begin
      logic [3:0] quiet [9];
      quiet = '{4'h0, 4'h1, 4'h3, 4'h6, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF};
      for (int q = 0; q < 9; q++) begin
        run(quiet[q], 4'(q), 4'(q + 3), 4'(q + 6), "R8 quiet opcode");
      end
    end
    dump_regs("R8 registers unchanged");

    // R9: exec_en low with a writing opcode presented
    @(negedge clk);
    opcode = 4'h2; fld_a = 4'h1; fld_b = 4'hF; fld_c = 4'hF; exec_en = 1'b0;
    @(negedge clk);
    check8("R9 wb_data held", wb_data, mres);
    check1("R9 eq_flag held", eq_flag, meq);
    run(4'h4, 4'h0, 4'h1, 4'h1, "R9 reg1 unchanged");

    // R10: overlap uses old value; back-to-back sees new value
    load(4'h1, 8'h40, "R10 setup");
    run(4'h5, 4'h1, 4'h1, 4'h1, "R10 overlap");
    check8("R10 old-value double", wb_data, 8'h80);
    meq = (mrf[2] == mrf[0]);
    @(negedge clk);
    opcode = 4'h2; fld_a = 4'h2; fld_b = 4'h1; fld_c = 4'h1; exec_en = 1'b1;
    @(negedge clk);
    opcode = 4'h5; fld_a = 4'h3; fld_b = 4'h2; fld_c = 4'h2;
    @(negedge clk);
    exec_en = 1'b0;
    mrf[2] = 8'h11; mrf[3] = 8'h22; mres = 8'h22;
    check8("R10 back-to-back", wb_data, 8'h22);
    check1("R10 back-to-back eq", eq_flag, meq);
    dump_regs("R10 read back");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule